// File: doc/BRIEF.md
# Two-Cache Snooping Invalidate Coherence Pair

This block holds two small write-through caches that share a single bus and a single backing memory. Each cache has its own CPU-side request port. A read that finds a valid, matching line is answered locally. A read that misses, and every write, becomes one transaction on the shared bus. A two-requester arbiter grants that transaction. Every bus write is also an invalidate. The other cache watches the bus and drops any valid copy of the written address. Stale data therefore never survives in the second cache, and its next read of that address misses and fetches the new value from memory.

Each cache is direct-mapped with one data word per line. The low address bits pick the line and the remaining bits form the tag. A write stores to memory and installs the word in the writer's own line in the same bus cycle. The bus carries one transaction per cycle, so all writes to a location reach memory and both caches in one global order.

Top module: `snoop_coh_pair`

## Requirements
- R1: After reset no response is pending, every line of both caches is invalid and every memory word reads as zero. The first read of any address therefore misses and returns 0.
- R2: A read miss uses one bus transaction. Its response comes 2 cycles after the request is accepted, with rsp_hit = 0 and the memory word as data.
- R3: A read hit uses no bus transaction. Its response comes 1 cycle after acceptance, with rsp_hit = 1 and the cached word.
- R4: A write always goes on the bus. In that same transaction it updates memory and the writer's own line. Its response comes 2 cycles after acceptance when the bus is free, with rsp_hit = 0 and the written word echoed on rsp_rdata.
- R5: When a bus write from the other cache matches a valid line (same index and tag), that line becomes invalid at the clock edge that ends the transaction. The next read of that address misses and returns the newly written value.
- R6: A cache never invalidates its own line because of its own bus write. A read that follows its own write hits and returns the written word.
- R7: A bus read by the other cache leaves this cache's lines unchanged.
- R8: A bus write to an address that shares a line index but has a different tag leaves the line valid. With 4 lines, addresses 1 and 5 share index 1.
- R9: At most one cache is granted per cycle. Cache 0 wins the first tie after reset, and the winner alternates on each later tie. A cache that loses a tie is granted in the next cycle, so its response comes 3 cycles after acceptance.
- R10: Writes to one address are ordered by the bus. After simultaneous writes, memory and both caches settle on the value of the write granted second.
- R11: A request is accepted only while the cache is idle and its previous response pulse has ended. rsp_done is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 2 | Request per cache, held until rsp_done |
| cpu_we | input | 2 | 1 = write, 0 = read, per cache |
| cpu_addr | input | 2 x AW | Word address per cache |
| cpu_wdata | input | 2 x DW | Write data per cache |
| rsp_done | output | 2 | One-cycle completion pulse per cache |
| rsp_hit | output | 2 | Response was served from the local line |
| rsp_rdata | output | 2 x DW | Read data, or the echoed write data |

## Verification
The number of cycles a response takes is part of its expected value. From the edge that accepts the request, a read hit answers in 1 cycle, a miss or a write on a free bus in 2, and the loser of a tie in 3. The driver records the cycle count when it raises a request. The monitor samples on the falling edge and compares the elapsed count together with the data and the hit flag. After each response the driver holds the request low for one cycle, so acceptance always happens at the first rising edge. Ties are produced by raising both requests on the same falling edge.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [0:0] {C_IDLE = 1'b0, C_BUS = 1'b1} cstate_e;
endpackage

// File: rtl/coh_bus_arbiter.sv
module coh_bus_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] gnt
);
  logic prio_q, prio_d;
  logic tie;

  assign tie = &req;

  always_comb begin
    if (tie) gnt = prio_q ? 2'b10 : 2'b01;
    else     gnt = req;
    prio_d = tie ? ~prio_q : prio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prio_q <= 1'b0;
    else if (tie) prio_q <= prio_d;
  end

  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    p_grant_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[g] |-> req[g]);
  end
endmodule

// File: rtl/coh_shared_mem.sv
module coh_shared_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem_q [WORDS];

  assign rdata = mem_q[addr];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem_q[w] <= '0;
      else if (wr_en && addr == AW'(w))    mem_q[w] <= wdata;
    end
  end

  p_mem_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
  import coh_pkg::*;
#(
  parameter bit MY_ID = 1'b0,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int LINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          rsp_done,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          rq_we,
  output logic [AW-1:0] rq_addr,
  output logic [DW-1:0] rq_wdata,
  input  logic          bus_valid,
  input  logic          bus_owner,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  cstate_e st_q, st_d;
  logic          done_q, hit_q;
  logic [DW-1:0] rdata_q, rdata_d;
  logic [LINES-1:0] vld_q;
  logic [TW-1:0] tag_q [LINES];
  logic [DW-1:0] dat_q [LINES];

  logic [IW-1:0] lk_idx, snp_idx, rq_idx;
  logic lk_hit, accept, fast_hit, fill, snp_hit, done_d;

  assign lk_idx  = cpu_addr[IW-1:0];
  assign snp_idx = bus_addr[IW-1:0];
  assign rq_idx  = rq_addr[IW-1:0];
  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == cpu_addr[AW-1:IW]);
  assign snp_hit = bus_valid && bus_we && (bus_owner != MY_ID) &&
                   vld_q[snp_idx] && (tag_q[snp_idx] == bus_addr[AW-1:IW]);

  always_comb begin
    accept   = (st_q == C_IDLE) && cpu_req && !done_q;
    fast_hit = accept && !cpu_we && lk_hit;
    fill     = (st_q == C_BUS) && bus_gnt;
    done_d   = fast_hit || fill;
    st_d     = st_q;
    case (st_q)
      C_IDLE: if (accept && !fast_hit) st_d = C_BUS;
      C_BUS:  if (bus_gnt)             st_d = C_IDLE;
      default:                         st_d = C_IDLE;
    endcase
    if (fast_hit)   rdata_d = dat_q[lk_idx];
    else if (rq_we) rdata_d = rq_wdata;
    else            rdata_d = mem_rdata;
  end

  assign bus_req   = (st_q == C_BUS);
  assign rsp_done  = done_q;
  assign rsp_hit   = hit_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      hit_q  <= fast_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (done_d) rdata_q <= rdata_d;
    if (accept) begin
      rq_we    <= cpu_we;
      rq_addr  <= cpu_addr;
      rq_wdata <= cpu_wdata;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic own_fill, drop;
    assign own_fill = fill && (rq_idx == IW'(i));
    assign drop     = snp_hit && (snp_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        vld_q[i] <= 1'b0;
      else if (own_fill) vld_q[i] <= 1'b1;
      else if (drop)     vld_q[i] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (own_fill) begin
        tag_q[i] <= rq_addr[AW-1:IW];
        dat_q[i] <= rq_we ? rq_wdata : mem_rdata;
      end
    end
  end

  p_snoop_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit |=> !vld_q[$past(snp_idx)]);
  p_own_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_owner == MY_ID) |=> vld_q[$past(rq_idx)]);
  p_read_snoop_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_owner != MY_ID && !bus_gnt) |=> (vld_q == $past(vld_q)));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

// File: rtl/snoop_coh_pair.sv
module snoop_coh_pair #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int LINES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cpu_req,
  input  logic [1:0]          cpu_we,
  input  logic [1:0][AW-1:0]  cpu_addr,
  input  logic [1:0][DW-1:0]  cpu_wdata,
  output logic [1:0]          rsp_done,
  output logic [1:0]          rsp_hit,
  output logic [1:0][DW-1:0]  rsp_rdata
);
  logic [1:0]         breq, bgnt, rwe;
  logic [1:0][AW-1:0] raddr;
  logic [1:0][DW-1:0] rwdata;
  logic               bus_valid, bus_owner, bus_we;
  logic [AW-1:0]      bus_addr;
  logic [DW-1:0]      bus_wdata, mem_rdata;

  coh_bus_arbiter arb_i (.clk(clk), .rst_n(rst_n), .req(breq), .gnt(bgnt));

  assign bus_valid = |bgnt;
  assign bus_owner = bgnt[1];
  assign bus_we    = bus_valid && rwe[bus_owner];
  assign bus_addr  = raddr[bus_owner];
  assign bus_wdata = rwdata[bus_owner];

  coh_shared_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(mem_rdata));

  for (genvar c = 0; c < 2; c++) begin : g_cache
    coh_cache_ctrl #(.MY_ID(c[0]), .AW(AW), .DW(DW), .LINES(LINES)) cache_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req[c]), .cpu_we(cpu_we[c]), .cpu_addr(cpu_addr[c]),
      .cpu_wdata(cpu_wdata[c]), .rsp_done(rsp_done[c]), .rsp_hit(rsp_hit[c]),
      .rsp_rdata(rsp_rdata[c]), .bus_req(breq[c]), .bus_gnt(bgnt[c]),
      .rq_we(rwe[c]), .rq_addr(raddr[c]), .rq_wdata(rwdata[c]),
      .bus_valid(bus_valid), .bus_owner(bus_owner), .bus_we(bus_we),
      .bus_addr(bus_addr), .mem_rdata(mem_rdata));

    p_loser_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (breq[c] && !bgnt[c]) |=> bgnt[c]);
  end
endmodule

// File: tb/snoop_coh_pair_tb.sv
module snoop_coh_pair_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]       cpu_req = '0, cpu_we = '0;
  logic [1:0][3:0]  cpu_addr = '0;
  logic [1:0][7:0]  cpu_wdata = '0;
  logic [1:0]       rsp_done, rsp_hit;
  logic [1:0][7:0]  rsp_rdata;
  int cyc = 0, checks = 0, errors = 0;

  typedef struct { logic [7:0] d; logic h; int lat; int t0; string tg; } exp_t;
  exp_t sb0[$];
  exp_t sb1[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  snoop_coh_pair dut_i (.clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rsp_done(rsp_done),
    .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata));

  task automatic issue(input int c, input logic we, input logic [3:0] a,
                       input logic [7:0] wd, input logic [7:0] ed, input logic eh,
                       input int el, input string tg);
    exp_t e;
    e.d = ed; e.h = eh; e.lat = el; e.t0 = cyc; e.tg = tg;
    if (c == 0) sb0.push_back(e); else sb1.push_back(e);
    cpu_we[c] = we; cpu_addr[c] = a; cpu_wdata[c] = wd; cpu_req[c] = 1'b1;
    do @(negedge clk); while (!rsp_done[c]);
    cpu_req[c] = 1'b0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (rsp_done[c]) begin
          exp_t e;
          checks++;
          if ((c == 0 ? sb0.size() : sb1.size()) == 0) begin
            errors++;
            $display("FAIL scoreboard: cache %0d response with nothing expected", c);
          end else begin
            e = (c == 0) ? sb0.pop_front() : sb1.pop_front();
            if (rsp_rdata[c] !== e.d || rsp_hit[c] !== e.h || (cyc - e.t0) != e.lat) begin
              errors++;
              $display("FAIL %s cache %0d: data=%h hit=%b lat=%0d expected data=%h hit=%b lat=%0d",
                       e.tg, c, rsp_rdata[c], rsp_hit[c], cyc - e.t0, e.d, e.h, e.lat);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_done !== 2'b00) begin
      errors++;
      $display("FAIL R1 reset: rsp_done=%b expected 00", rsp_done);
    end
    issue(0, 0, 4'd3, 8'h00, 8'h00, 0, 2, "R1 R2 cold read A");
    issue(1, 0, 4'd3, 8'h00, 8'h00, 0, 2, "R1 R2 cold read B");
    issue(0, 1, 4'd3, 8'h11, 8'h11, 0, 2, "R4 write A");
    issue(0, 0, 4'd3, 8'h00, 8'h11, 1, 1, "R3 R6 own read after write");
    issue(1, 0, 4'd3, 8'h00, 8'h11, 0, 2, "R5 R4 B miss after invalidate");
    issue(0, 0, 4'd3, 8'h00, 8'h11, 1, 1, "R7 A kept line after B read");
    issue(0, 0, 4'd1, 8'h00, 8'h00, 0, 2, "R2 A read addr1");
    issue(1, 1, 4'd5, 8'h55, 8'h55, 0, 2, "R4 B write addr5");
    issue(0, 0, 4'd1, 8'h00, 8'h00, 1, 1, "R8 other tag keeps line");
    issue(0, 0, 4'd5, 8'h00, 8'h55, 0, 2, "R8 R4 addr5 from memory");
    fork
      issue(0, 0, 4'd9,  8'h00, 8'h00, 0, 2, "R9 first tie winner A");
      issue(1, 0, 4'd10, 8'h00, 8'h00, 0, 3, "R9 first tie loser B");
    join
    fork
      issue(0, 1, 4'd6, 8'hA6, 8'hA6, 0, 3, "R9 R10 second tie loser A");
      issue(1, 1, 4'd6, 8'hB6, 8'hB6, 0, 2, "R9 R10 second tie winner B");
    join
    issue(0, 0, 4'd6, 8'h00, 8'hA6, 1, 1, "R10 A holds last write");
    issue(1, 0, 4'd6, 8'h00, 8'hA6, 0, 2, "R10 B refetches last write");
    issue(1, 0, 4'd6, 8'h00, 8'hA6, 1, 1, "R3 R11 B hit after refetch");
    repeat (4) @(negedge clk);
    checks++;
    if (sb0.size() != 0 || sb1.size() != 0) begin
      errors++;
      $display("FAIL R11 responses missing: left=%0d expected 0", sb0.size() + sb1.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule